// File: doc/BRIEF.md
# Program/Erase Retry Sequencer

This block runs one non-volatile memory operation (erase, program or read) as a series of pulse-and-verify attempts. After a start request it first waits for a pending error status to clear. It then issues one pulse request per attempt and waits for a completion handshake, which comes with a verify result. An attempt whose verify reports an error is retried until the attempt budget of the operation type is spent.

A program operation needs one more pulse after its first passing verify. That extra pulse raises the attempt budget by one. A missing completion handshake aborts the whole operation at once, with no retry.

The pulse generator and the verify circuit are outside the block. The block only drives `pulse_o` and listens to `pulse_done_i` and `verify_fail_i`. The error-status poll interval and the completion timeout are parameters counted in clock cycles.

Top module: `flash_pe_seq`

## Requirements
- R1: With the block idle, a high `start_i` latches `op_i`, and `busy_o` is high from the next cycle. A `start_i` that arrives while `busy_o` is high has no effect on the running operation and starts nothing after it.
- R2: While busy and before the first pulse, `err_pending_i` is sampled once every POLL_CYC cycles, starting in the first busy cycle. The first pulse follows only a sample that sees it low. If ERR_CHECKS samples in a row see it high, the operation ends with `fail_o`, without any pulse and without `timeout_o`.
- R3: Each attempt drives `pulse_o` high for exactly one cycle and then waits for `pulse_done_i`. `verify_fail_i` is sampled in the cycle where `pulse_done_i` is high. A set `verify_fail_i` starts a new attempt if the budget allows.
- R4: The operation code on `op_i` is 2'b00 for erase, with a budget of ERASE_MAX attempts (default 45). Code 2'b01 is program, with PROG_MAX attempts (default 9). Codes 2'b10 and 2'b11 are read, with READ_MAX attempts (default 9). When every attempt in the budget fails verify, the operation ends with `fail_o` after exactly that many pulses.
- R5: On a program operation, the first passing verify is followed by exactly one more pulse, and the budget grows by one. Success is reported when a verify passes after that extra pulse.
- R6: On erase or read, the first passing verify ends the operation with `ok_o`, with no further pulse.
- R7: If `pulse_done_i` does not arrive within DONE_POLLS*POLL_CYC cycles of waiting, the operation ends with both `fail_o` and `timeout_o`, with no further pulse. `busy_o` falls DONE_POLLS*POLL_CYC+1 cycles after the last `pulse_o` cycle.
- R8: `ok_o`, `fail_o` and `timeout_o` are one-cycle pulses that appear in the first cycle with `busy_o` low. `ok_o` and `fail_o` are never high together, and `timeout_o` is only high with `fail_o`.
- R9: The attempt count and the extra-pulse flag are cleared at every start, so each operation gets its full budget whatever the previous one used.
- R10: During and right after reset, `busy_o`, `pulse_o`, `ok_o`, `fail_o` and `timeout_o` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, taken only when idle |
| op_i | input | 2 | Operation code: 00 erase, 01 program, 10/11 read |
| err_pending_i | input | 1 | Self-clearing error status that must be low before the first pulse |
| pulse_o | output | 1 | One-cycle request for one program/erase/read pulse |
| pulse_done_i | input | 1 | Pulse finished; verify result valid this cycle |
| verify_fail_i | input | 1 | Verify reported errors for the finished pulse |
| busy_o | output | 1 | Operation in progress |
| ok_o | output | 1 | Operation succeeded (one cycle) |
| fail_o | output | 1 | Operation failed or was refused (one cycle) |
| timeout_o | output | 1 | Failure was caused by a missing completion (one cycle, with fail_o) |

## Verification
The responder in the bench answers each pulse after a chosen delay. The first N verifies fail, and the answer can be withheld entirely at a chosen attempt. The run of failures is set to just under and exactly at each operation's budget, which tells the erase budget apart from the program and read budgets. A program run whose verify passes on its last budgeted attempt must still get its extra pulse. Hangs on the first attempt, on a retried attempt and on the extra program pulse show that a timeout stops retries at once. Separate runs cover an error status that clears in time and one that never clears, a start raised during a busy run, and an operation right after an exhausted one.

// File: rtl/pe_seq_pkg.sv
package pe_seq_pkg;

  typedef enum logic [1:0] {
    OP_ERASE    = 2'b00,
    OP_PROG     = 2'b01,
    OP_READ     = 2'b10,
    OP_READ_ALT = 2'b11
  } pe_op_e;

  typedef enum logic [1:0] {
    S_IDLE   = 2'd0,
    S_PRECHK = 2'd1,
    S_PULSE  = 2'd2,
    S_WAIT   = 2'd3
  } pe_state_e;

endpackage

// File: rtl/pe_poll_timer.sv
module pe_poll_timer #(
  parameter int POLL_CYC = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);

  localparam int W = (POLL_CYC > 1) ? $clog2(POLL_CYC) : 1;

  generate
    if (POLL_CYC > 1) begin : g_div
      logic [W-1:0] cnt_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                           cnt_q <= '0;
        else if (!en_i)                        cnt_q <= '0;
        else if (cnt_q == W'(POLL_CYC - 1))    cnt_q <= '0;
        else                                   cnt_q <= cnt_q + 1'b1;
      end

      assign tick_o = en_i && (cnt_q == '0);

      // consecutive samples are at least two cycles apart
      p_tick_gap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end else begin : g_every
      assign tick_o = en_i;
    end
  endgenerate

endmodule

// File: rtl/pe_win_cnt.sv
module pe_win_cnt #(
  parameter int LIMIT = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic hit_o
);

  localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;

  logic [W-1:0] cnt_q;

  assign hit_o = (cnt_q == W'(LIMIT - 1));

  // saturates at the hit value
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i)           cnt_q <= '0;
    else if (inc_i && !hit_o) cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/pe_attempt_ctr.sv
module pe_attempt_ctr
  import pe_seq_pkg::*;
#(
  parameter int ERASE_MAX = 45,
  parameter int PROG_MAX  = 9,
  parameter int READ_MAX  = 9
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   clr_i,
  input  pe_op_e op_i,
  input  logic   step_i,
  input  logic   extra_i,
  output logic   last_o,
  output logic   extra_used_o
);

  localparam int MAX_AB = (ERASE_MAX > PROG_MAX) ? ERASE_MAX : PROG_MAX;
  localparam int MAX_ALL = (MAX_AB > READ_MAX) ? MAX_AB : READ_MAX;
  localparam int CW = $clog2(MAX_ALL + 2);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] limit;
  logic          extra_q;

  always_comb begin
    unique case (op_i)
      OP_ERASE: limit = CW'(ERASE_MAX);
      OP_PROG:  limit = CW'(PROG_MAX);
      default:  limit = CW'(READ_MAX);
    endcase
    if (extra_q) limit = limit + 1'b1;
  end

  // the attempt now finishing is the last the budget allows
  assign last_o       = (cnt_q + 1'b1) >= limit;
  assign extra_used_o = extra_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      extra_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q   <= '0;
      extra_q <= 1'b0;
    end else begin
      if (step_i)  cnt_q   <= cnt_q + 1'b1;
      if (extra_i) extra_q <= 1'b1;
    end
  end

  p_cnt_le_limit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= limit);

  p_extra_once_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    extra_i |-> (step_i && !extra_q));

  p_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0 && !extra_q));

endmodule

// File: rtl/flash_pe_seq.sv
module flash_pe_seq
  import pe_seq_pkg::*;
#(
  parameter int ERASE_MAX  = 45,
  parameter int PROG_MAX   = 9,
  parameter int READ_MAX   = 9,
  parameter int POLL_CYC   = 100,
  parameter int DONE_POLLS = 1500,
  parameter int ERR_CHECKS = 50
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [1:0] op_i,
  input  logic       err_pending_i,
  output logic       pulse_o,
  input  logic       pulse_done_i,
  input  logic       verify_fail_i,
  output logic       busy_o,
  output logic       ok_o,
  output logic       fail_o,
  output logic       timeout_o
);

  localparam int TIMEOUT_CYC = DONE_POLLS * POLL_CYC;

  pe_state_e state_q, state_d;
  pe_op_e    op_q;
  logic      ok_d, fail_d, tmo_d;
  logic      ok_q, fail_q, tmo_q;
  logic      att_clr, att_step, att_extra, att_last, extra_used;
  logic      poll_tick, chk_hit, wait_hit;

  pe_poll_timer #(.POLL_CYC(POLL_CYC)) u_poll (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (state_q == S_PRECHK),
    .tick_o (poll_tick)
  );

  // pending-error samples seen so far
  pe_win_cnt #(.LIMIT(ERR_CHECKS)) u_chk_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (state_q != S_PRECHK),
    .inc_i  (poll_tick && err_pending_i),
    .hit_o  (chk_hit)
  );

  // cycles spent waiting for completion
  pe_win_cnt #(.LIMIT(TIMEOUT_CYC)) u_wait_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (state_q != S_WAIT),
    .inc_i  (state_q == S_WAIT),
    .hit_o  (wait_hit)
  );

  pe_attempt_ctr #(
    .ERASE_MAX (ERASE_MAX),
    .PROG_MAX  (PROG_MAX),
    .READ_MAX  (READ_MAX)
  ) u_att (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clr_i        (att_clr),
    .op_i         (op_q),
    .step_i       (att_step),
    .extra_i      (att_extra),
    .last_o       (att_last),
    .extra_used_o (extra_used)
  );

  always_comb begin
    state_d   = state_q;
    ok_d      = 1'b0;
    fail_d    = 1'b0;
    tmo_d     = 1'b0;
    att_clr   = 1'b0;
    att_step  = 1'b0;
    att_extra = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (start_i) begin
          state_d = S_PRECHK;
          att_clr = 1'b1;
        end
      end
      S_PRECHK: begin
        if (poll_tick) begin
          if (!err_pending_i) begin
            state_d = S_PULSE;
          end else if (chk_hit) begin
            state_d = S_IDLE;
            fail_d  = 1'b1;
          end
        end
      end
      S_PULSE: state_d = S_WAIT;
      S_WAIT: begin
        if (pulse_done_i) begin
          if (verify_fail_i) begin
            if (att_last) begin
              state_d = S_IDLE;
              fail_d  = 1'b1;
            end else begin
              att_step = 1'b1;
              state_d  = S_PULSE;
            end
          end else if (op_q == OP_PROG && !extra_used) begin
            // one more pulse after the first pass, budget grows by one
            att_step  = 1'b1;
            att_extra = 1'b1;
            state_d   = S_PULSE;
          end else begin
            state_d = S_IDLE;
            ok_d    = 1'b1;
          end
        end else if (wait_hit) begin
          state_d = S_IDLE;
          fail_d  = 1'b1;
          tmo_d   = 1'b1;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      op_q    <= OP_ERASE;
      ok_q    <= 1'b0;
      fail_q  <= 1'b0;
      tmo_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ok_q    <= ok_d;
      fail_q  <= fail_d;
      tmo_q   <= tmo_d;
      if (state_q == S_IDLE && start_i) op_q <= pe_op_e'(op_i);
    end
  end

  assign busy_o    = (state_q != S_IDLE);
  assign pulse_o   = (state_q == S_PULSE);
  assign ok_o      = ok_q;
  assign fail_o    = fail_q;
  assign timeout_o = tmo_q;

  p_start_ignored_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(op_q));

  p_pulse_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |-> busy_o);

  p_pulse_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);

  p_ok_prog_extra_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ok_o && op_q == OP_PROG) |-> extra_used);

  p_tmo_with_fail_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> fail_o);

  p_ok_fail_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ok_o && fail_o));

  p_end_at_busy_fall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ok_o || fail_o) |-> (!busy_o && $past(busy_o)));

  p_end_one_cycle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ok_o || fail_o) |=> !(ok_o || fail_o));

endmodule

// File: tb/flash_pe_seq_tb.sv
module flash_pe_seq_tb;
  import pe_seq_pkg::*;

  localparam int POLL  = 2;
  localparam int DPOLL = 5;
  localparam int ECHK  = 3;
  localparam int TCYC  = POLL * DPOLL;
  localparam int NV    = 16;

  typedef struct packed {
    logic [1:0] op;
    logic [7:0] err_hold;
    logic [7:0] nfail;
    logic [7:0] hang;
    logic [7:0] ign;
    logic [3:0] dly;
    logic       exp_ok;
    logic       exp_tmo;
    logic [7:0] exp_pulses;
  } vec_t;

  // op, err_hold, nfail, hang(255 none), ign(255 none), dly, ok, tmo, pulses
  localparam vec_t VECS [NV] = '{
    '{2'b00, 8'd0,  8'd0,  8'd255, 8'd255, 4'd0, 1'b1, 1'b0, 8'd1},
    '{2'b01, 8'd0,  8'd0,  8'd255, 8'd255, 4'd1, 1'b1, 1'b0, 8'd2},
    '{2'b10, 8'd0,  8'd2,  8'd255, 8'd255, 4'd2, 1'b1, 1'b0, 8'd3},
    '{2'b01, 8'd0,  8'd3,  8'd255, 8'd255, 4'd0, 1'b1, 1'b0, 8'd5},
    '{2'b10, 8'd0,  8'd9,  8'd255, 8'd255, 4'd0, 1'b0, 1'b0, 8'd9},
    '{2'b01, 8'd0,  8'd8,  8'd255, 8'd255, 4'd1, 1'b1, 1'b0, 8'd10},
    '{2'b01, 8'd0,  8'd9,  8'd255, 8'd255, 4'd0, 1'b0, 1'b0, 8'd9},
    '{2'b00, 8'd0,  8'd44, 8'd255, 8'd255, 4'd0, 1'b1, 1'b0, 8'd45},
    '{2'b00, 8'd0,  8'd45, 8'd255, 8'd255, 4'd0, 1'b0, 1'b0, 8'd45},
    '{2'b01, 8'd0,  8'd0,  8'd0,   8'd255, 4'd0, 1'b0, 1'b1, 8'd1},
    '{2'b00, 8'd0,  8'd2,  8'd2,   8'd255, 4'd3, 1'b0, 1'b1, 8'd3},
    '{2'b01, 8'd0,  8'd0,  8'd1,   8'd255, 4'd0, 1'b0, 1'b1, 8'd2},
    '{2'b01, 8'd3,  8'd0,  8'd255, 8'd255, 4'd0, 1'b1, 1'b0, 8'd2},
    '{2'b10, 8'd99, 8'd0,  8'd255, 8'd255, 4'd0, 1'b0, 1'b0, 8'd0},
    '{2'b11, 8'd0,  8'd9,  8'd255, 8'd255, 4'd0, 1'b0, 1'b0, 8'd9},
    '{2'b01, 8'd0,  8'd3,  8'd255, 8'd6,   4'd1, 1'b1, 1'b0, 8'd5}
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [1:0] op_i = 2'b00;
  logic       err_pending_i = 1'b0;
  logic       pulse_done_i = 1'b0;
  logic       verify_fail_i = 1'b0;
  logic       pulse_o, busy_o, ok_o, fail_o, timeout_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2 clk_i = ~clk_i;

  flash_pe_seq #(
    .POLL_CYC   (POLL),
    .DONE_POLLS (DPOLL),
    .ERR_CHECKS (ECHK)
  ) u_dut (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (start_i),
    .op_i          (op_i),
    .err_pending_i (err_pending_i),
    .pulse_o       (pulse_o),
    .pulse_done_i  (pulse_done_i),
    .verify_fail_i (verify_fail_i),
    .busy_o        (busy_o),
    .ok_o          (ok_o),
    .fail_o        (fail_o),
    .timeout_o     (timeout_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run_op(input vec_t v, input int idx);
    int   pulses = 0;
    int   cd = -1;
    int   cur = 0;
    int   last_p = 0;
    int   n = 0;
    logic r_ok = 1'b0, r_fail = 1'b0, r_tmo = 1'b0;
    @(negedge clk_i);
    start_i       = 1'b1;
    op_i          = v.op;
    err_pending_i = (v.err_hold != 0);
    forever begin
      @(negedge clk_i);
      start_i       = 1'b0;
      pulse_done_i  = 1'b0;
      verify_fail_i = 1'b0;
      if (n == 0) check($sformatf("R1 busy after start, vec %0d", idx), int'(busy_o), 1);
      if (v.err_hold != 0 && n >= int'(v.err_hold)) err_pending_i = 1'b0;
      if (n == int'(v.ign)) begin
        start_i = 1'b1;
        op_i    = 2'b00;
      end
      if (cd > 0) begin
        cd--;
        if (cd == 0) begin
          pulse_done_i  = 1'b1;
          verify_fail_i = (cur < int'(v.nfail));
          cd = -1;
        end
      end
      if (pulse_o) begin
        last_p = n;
        cur    = pulses;
        if (pulses != int'(v.hang)) cd = int'(v.dly) + 1;
        pulses++;
      end
      if (!busy_o && n > 0) begin
        r_ok = ok_o; r_fail = fail_o; r_tmo = timeout_o;
        break;
      end
      if (n > 5000) break;
      n++;
    end
    start_i       = 1'b0;
    pulse_done_i  = 1'b0;
    err_pending_i = 1'b0;
    check($sformatf("R4 R5 R6 ok at busy fall, vec %0d", idx), int'(r_ok), int'(v.exp_ok));
    check($sformatf("R3 R8 fail at busy fall, vec %0d", idx), int'(r_fail), int'(!v.exp_ok));
    check($sformatf("R7 timeout flag, vec %0d", idx), int'(r_tmo), int'(v.exp_tmo));
    check($sformatf("R2 R3 R4 R5 pulse count, vec %0d", idx), pulses, int'(v.exp_pulses));
    if (v.exp_tmo)
      check($sformatf("R7 abort delay, vec %0d", idx), n - last_p, TCYC + 1);
    @(negedge clk_i);
    check($sformatf("R8 results one cycle, vec %0d", idx),
          int'({ok_o, fail_o, timeout_o}), 0);
    check($sformatf("R1 R9 idle after end, vec %0d", idx), int'(busy_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R10 reset state
    check("R10 outputs in reset", int'({busy_o, pulse_o, ok_o, fail_o, timeout_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R10 outputs after reset", int'({busy_o, pulse_o, ok_o, fail_o, timeout_o}), 0);

    for (int i = 0; i < NV; i++) run_op(VECS[i], i);

    // R1: the start seen in the busy run of the last vector must not launch anything
    repeat (3) @(negedge clk_i);
    check("R1 ignored start left no pending op", int'(busy_o), 0);

    // R9: a fresh program run after exhausted budgets gets its full budget again
    run_op(VECS[5], 100);

    finished = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!finished && cyc < 100000) begin
      @(posedge clk_i);
      cyc++;
    end
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule